// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds a set of privileged control registers that are reached by a 5-bit index. Privileged instructions use it to read and write them. Each register has its own write mask and its own rules for reads and writes. A request that is illegal for its index comes back as a fault with zero data and changes nothing. Some writes have a side effect instead of plain storage:
- A write to either exception register clears it.
- Writes to the invalidate registers send one-cycle flush commands to the translation-buffer logic.
- A write to the tag register sends an insert command. The command carries the tag and a page entry assembled from the stored page-entry register and the current address-space number.

The cycle-count register combines two sources when read. The upper half comes from the stored value and the lower half from a live counter that runs freely from reset.

Requests take one cycle. A request presented with `req_valid` on a rising edge is answered after that edge by `rsp_valid`, which is high for one cycle. Any flush or insert command is aligned with that response.

The response tracker is a four-state machine:
- `ST_IDLE`: no request was presented.
- `ST_RACK`: a legal read was presented.
- `ST_WACK`: a legal write was presented.
- `ST_FAULT`: an illegal request or an unmapped index was presented.

On every clock the next state depends only on the current request. With no request the next state is `ST_IDLE`. Otherwise it is `ST_RACK`, `ST_WACK` or `ST_FAULT` according to the request's legality, so any state can move to any other.

Register index map:

| Index | Register | Access |
|---|---|---|
| 0 | priority level | read/write |
| 1 | async-trap request | read/write |
| 2 | async-trap enable | read/write |
| 3 | instruction mode | read/write |
| 4 | data mode | read/write |
| 5 | software interrupt request | read/write |
| 6 | restart address | read/write |
| 7 | exception summary | read/write |
| 8 | exception mask | read/write |
| 9 | interrupt ID | read-only |
| 10 | MM status | read-only |
| 11 | page-entry temp | read-only |
| 12 | cycle count | read/write |
| 13 | interrupt clear | write-only |
| 14 | invalidate all | write-only |
| 15 | invalidate by process | write-only |
| 16 | invalidate one | write-only |
| 17 | address-space number | read/write |
| 18 | page entry | read/write |
| 19 | tag | read/write |
| 20–31 | unmapped | none |

Top module: `ctlreg_bank`

## Requirements
- R1: A write to the priority-level register (index 0) stores only data bits [4:0]; a read returns them with all other bits 0.
- R2: Writes to the async-trap request and enable registers (indices 1, 2) store only data bits [3:0].
- R3: Writes to the two mode registers (indices 3, 4) store only the bits under mask 0x18.
- R4: A write to the software-interrupt request register (index 5) stores only the bits under mask 0x7fff0.
- R5: A write to the restart-address register (index 6) stores the data with bit 1 forced to 0.
- R6: Any write to the exception-summary or exception-mask register (indices 7, 8) leaves it 0, whatever the data.
- R7: A write to a read-only register (indices 9, 10, 11) is answered with a fault and leaves the register unchanged. These registers read as 0 without a fault.
- R8: A read of a write-only register (indices 13 to 16) returns data 0 and a fault.
- R9: A read of the cycle-count register (index 12) returns the stored bits [63:32] above the 32-bit live counter. The counter advances by one on each clock edge.
- R10: A write to invalidate-all (index 14) or invalidate-by-process (index 15) produces a single-cycle pulse on `flush_all` or `flush_proc` respectively, aligned with the response.
- R11: A write to invalidate-one (index 16) pulses `flush_one` with `flush_addr` equal to the write data and `flush_asn` equal to bits [6:0] of the address-space number register (index 17).
- R12: A read of the page-entry register (index 18) returns the stored fields at these positions, with every other bit 0:

  | Field | Bits |
  |---|---|
  | fault-on-read | 1 |
  | fault-on-write | 2 |
  | match-any-space | 4 |
  | read enables | [11:8] |
  | write enables | [15:12] |
  | frame number | [58:32] |

  Bits [6:0] of the address-space number are ORed in at [63:57]. A write to the tag register (index 19) pulses `ins_pulse` with `ins_tag` equal to the data and `ins_entry` equal to that same assembled word.
- R13: A read or write to an unmapped index (20 to 31) is answered with a fault and changes no register.
- R14: After reset every register reads 0 and no response or pulse is active. Each request is answered exactly one cycle later, and `rsp_valid` is low after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 5 | Register index |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 1 | The request was illegal |
| rsp_rdata | output | 64 | Read data (0 on writes and faults) |
| flush_all | output | 1 | Flush every translation entry |
| flush_proc | output | 1 | Flush per-process translation entries |
| flush_one | output | 1 | Flush one address |
| flush_addr | output | 64 | Address for `flush_one` |
| flush_asn | output | 7 | Address-space number for `flush_one` |
| ins_pulse | output | 1 | Insert a translation entry |
| ins_tag | output | 64 | Tag for the insert |
| ins_entry | output | 64 | Assembled page entry for the insert |

## Verification
The assertions watch several properties on every cycle:
- The flush and insert pulses are mutually exclusive, and each comes only with a successful response.
- A faulted response always carries zero data.
- An unmapped index always faults.
- Priority-level reads never show bits above bit 4, and restart-address reads never show bit 1.
- An idle cycle is never followed by a response.

The bench scenarios are needed for the behaviours that depend on data:
- the per-register masks and the clearing writes;
- the refusal of read-only writes;
- the live lower half of the cycle count;
- the bit placement of the assembled page entry and the address-space number that comes with each flush or insert.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
    localparam int DW    = 64;
    localparam int IDX_W = 5;
    localparam int NREG  = 20;
    localparam int ASN_W = 7;

    // page entry field placement (decoded by translation logic)
    localparam int PFN_LSB = 32;
    localparam int PFN_W   = 27;
    localparam int RDE_LSB = 8;
    localparam int WRE_LSB = 12;
    localparam int EN_W    = 4;
    localparam int FOR_BIT = 1;
    localparam int FOW_BIT = 2;
    localparam int ASM_BIT = 4;
    localparam int ASN_LSB = 57;

    typedef enum logic [IDX_W-1:0] {
        CR_IPL = 5'd0, CR_ASTRQ = 5'd1, CR_ASTEN = 5'd2, CR_IMODE = 5'd3,
        CR_DMODE = 5'd4, CR_SWINT = 5'd5, CR_RESTART = 5'd6, CR_EXCSUM = 5'd7,
        CR_EXCMSK = 5'd8, CR_INTID = 5'd9, CR_MMSTAT = 5'd10, CR_PTETMP = 5'd11,
        CR_CYCLE = 5'd12, CR_HWCLR = 5'd13, CR_INVALL = 5'd14, CR_INVPROC = 5'd15,
        CR_INVONE = 5'd16, CR_ASN = 5'd17, CR_PTE = 5'd18, CR_TAG = 5'd19
    } creg_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RACK, ST_WACK, ST_FAULT} ack_st_e;
    typedef enum logic [2:0] {PK_NONE, PK_ALL, PK_PROC, PK_ONE, PK_INS} pulse_e;
    typedef enum logic [1:0] {RK_PLAIN, RK_CYCLE, RK_PTE} rdkind_e;

    function automatic logic [DW-1:0] pte_assemble(input logic [DW-1:0] raw,
                                                   input logic [ASN_W-1:0] asn);
        logic [DW-1:0] w;
        w = '0;
        w[PFN_LSB +: PFN_W] = raw[PFN_LSB +: PFN_W];
        w[RDE_LSB +: EN_W]  = raw[RDE_LSB +: EN_W];
        w[WRE_LSB +: EN_W]  = raw[WRE_LSB +: EN_W];
        w[FOR_BIT]          = raw[FOR_BIT];
        w[FOW_BIT]          = raw[FOW_BIT];
        w[ASM_BIT]          = raw[ASM_BIT];
        w[ASN_LSB +: ASN_W] = w[ASN_LSB +: ASN_W] | asn;
        return w;
    endfunction
endpackage

// File: rtl/ctlreg_decode.sv
`timescale 1ns/1ps
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic [DW-1:0]    wmask,
    output logic             wclr,
    output pulse_e           pk,
    output rdkind_e          rk
);
    always_comb begin
        rd_ok = 1'b1;
        wr_ok = 1'b1;
        wmask = '1;
        wclr  = 1'b0;
        pk    = PK_NONE;
        rk    = RK_PLAIN;
        unique case (idx)
            CR_IPL:               wmask = DW'(64'h1f);
            CR_ASTRQ, CR_ASTEN:   wmask = DW'(64'hf);
            CR_IMODE, CR_DMODE:   wmask = DW'(64'h18);
            CR_SWINT:             wmask = DW'(64'h7fff0);
            CR_RESTART:           wmask = ~DW'(64'h2);
            CR_EXCSUM, CR_EXCMSK: wclr  = 1'b1;
            CR_INTID, CR_MMSTAT, CR_PTETMP: wr_ok = 1'b0;
            CR_CYCLE:             rk    = RK_CYCLE;
            CR_HWCLR:             rd_ok = 1'b0;
            CR_INVALL: begin rd_ok = 1'b0; wclr = 1'b1; pk = PK_ALL;  end
            CR_INVPROC: begin rd_ok = 1'b0; wclr = 1'b1; pk = PK_PROC; end
            CR_INVONE: begin rd_ok = 1'b0; pk = PK_ONE; end
            CR_ASN:               wmask = '1;
            CR_PTE:               rk    = RK_PTE;
            CR_TAG:               pk    = PK_INS;
            default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ctlreg_cycle.sv
`timescale 1ns/1ps
module ctlreg_cycle #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(1);
    end
endmodule

// File: rtl/ctlreg_bank.sv
`timescale 1ns/1ps
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DW-1:0]     rsp_rdata,
    output logic              flush_all,
    output logic              flush_proc,
    output logic              flush_one,
    output logic [DW-1:0]     flush_addr,
    output logic [ASN_W-1:0]  flush_asn,
    output logic              ins_pulse,
    output logic [DW-1:0]     ins_tag,
    output logic [DW-1:0]     ins_entry
);
    logic [DW-1:0]    bank [NREG];
    logic             d_rd_ok, d_wr_ok, d_wclr;
    logic [DW-1:0]    d_wmask;
    pulse_e           d_pk;
    rdkind_e          d_rk;
    logic [CNT_W-1:0] cyc;
    logic             wr_hit;
    logic [DW-1:0]    raw, rd_val, pte_word;
    logic [ASN_W-1:0] asn_cur;
    ack_st_e          state, nxt;
    logic [IDX_W-1:0] rsp_idx;

    ctlreg_decode u_dec (
        .idx(req_idx), .rd_ok(d_rd_ok), .wr_ok(d_wr_ok),
        .wmask(d_wmask), .wclr(d_wclr), .pk(d_pk), .rk(d_rk)
    );

    ctlreg_cycle #(.W(CNT_W)) u_cyc (.clk(clk), .rst_n(rst_n), .count(cyc));

    assign wr_hit = req_valid && req_write && d_wr_ok;

    // storage: one masked write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++)
                if (wr_hit && req_idx == IDX_W'(i))
                    bank[i] <= d_wclr ? '0 : (req_wdata & d_wmask);
        end
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < NREG; i++)
            if (req_idx == IDX_W'(i)) raw = bank[i];
    end

    assign asn_cur  = bank[int'(CR_ASN)][ASN_W-1:0];
    assign pte_word = pte_assemble(bank[int'(CR_PTE)], asn_cur);

    always_comb begin
        unique case (d_rk)
            RK_CYCLE: rd_val = {raw[DW-1:CNT_W], cyc};
            RK_PTE:   rd_val = pte_assemble(raw, asn_cur);
            default:  rd_val = raw;
        endcase
    end

    // next-state decision
    always_comb begin
        if (!req_valid)     nxt = ST_IDLE;
        else if (req_write) nxt = d_wr_ok ? ST_WACK : ST_FAULT;
        else                nxt = d_rd_ok ? ST_RACK : ST_FAULT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata  <= '0;
            rsp_idx    <= '0;
            flush_all  <= 1'b0;
            flush_proc <= 1'b0;
            flush_one  <= 1'b0;
            flush_addr <= '0;
            flush_asn  <= '0;
            ins_pulse  <= 1'b0;
            ins_tag    <= '0;
            ins_entry  <= '0;
        end else begin
            rsp_rdata  <= (nxt == ST_RACK) ? rd_val : '0;
            rsp_idx    <= req_idx;
            flush_all  <= wr_hit && d_pk == PK_ALL;
            flush_proc <= wr_hit && d_pk == PK_PROC;
            flush_one  <= wr_hit && d_pk == PK_ONE;
            flush_addr <= (wr_hit && d_pk == PK_ONE) ? req_wdata : '0;
            flush_asn  <= (wr_hit && d_pk == PK_ONE) ? asn_cur : '0;
            ins_pulse  <= wr_hit && d_pk == PK_INS;
            ins_tag    <= (wr_hit && d_pk == PK_INS) ? req_wdata : '0;
            ins_entry  <= (wr_hit && d_pk == PK_INS) ? pte_word : '0;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_fault = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_fault = 1'b1; end
            default:  begin rsp_valid = 1'b1; rsp_fault = 1'b0; end
        endcase
    end

    // R13
    unmapped_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx >= IDX_W'(NREG)) |=> (rsp_valid && rsp_fault));

    // R8
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == '0));

    // R10
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_all, flush_proc, flush_one, ins_pulse}));

    // R11
    pulse_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all || flush_proc || flush_one || ins_pulse) |-> (rsp_valid && !rsp_fault));

    // R1
    ipl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_idx == CR_IPL) |-> (rsp_rdata[DW-1:5] == '0));

    // R5
    restart_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_idx == CR_RESTART) |-> !rsp_rdata[1]);

    // R14
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/ctlreg_bank_tb.sv
`timescale 1ns/1ps
module ctlreg_bank_tb_top;
    import ctlreg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_fault, flush_all, flush_proc, flush_one, ins_pulse;
    logic [63:0] rsp_rdata, flush_addr, ins_tag, ins_entry;
    logic [6:0]  flush_asn;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    ctlreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .flush_all(flush_all),
        .flush_proc(flush_proc), .flush_one(flush_one), .flush_addr(flush_addr),
        .flush_asn(flush_asn), .ins_pulse(ins_pulse), .ins_tag(ins_tag),
        .ins_entry(ins_entry)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  idx;
        logic [63:0] wd;
        logic        flt;
        logic [63:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b1, CR_IPL,     '1,                    1'b0, 64'h0, 4'd1},   // R1
        '{1'b0, CR_IPL,     64'h0,                 1'b0, 64'h1f, 4'd1},
        '{1'b1, CR_ASTRQ,   64'hff,                1'b0, 64'h0, 4'd2},   // R2
        '{1'b0, CR_ASTRQ,   64'h0,                 1'b0, 64'hf, 4'd2},
        '{1'b1, CR_ASTEN,   64'h35,                1'b0, 64'h0, 4'd2},
        '{1'b0, CR_ASTEN,   64'h0,                 1'b0, 64'h5, 4'd2},
        '{1'b1, CR_IMODE,   64'hff,                1'b0, 64'h0, 4'd3},   // R3
        '{1'b0, CR_IMODE,   64'h0,                 1'b0, 64'h18, 4'd3},
        '{1'b1, CR_DMODE,   64'h8,                 1'b0, 64'h0, 4'd3},
        '{1'b0, CR_DMODE,   64'h0,                 1'b0, 64'h8, 4'd3},
        '{1'b1, CR_SWINT,   '1,                    1'b0, 64'h0, 4'd4},   // R4
        '{1'b0, CR_SWINT,   64'h0,                 1'b0, 64'h7fff0, 4'd4},
        '{1'b1, CR_RESTART, 64'h12345677,          1'b0, 64'h0, 4'd5},   // R5
        '{1'b0, CR_RESTART, 64'h0,                 1'b0, 64'h12345675, 4'd5},
        '{1'b1, CR_EXCSUM,  64'hdead,              1'b0, 64'h0, 4'd6},   // R6
        '{1'b0, CR_EXCSUM,  64'h0,                 1'b0, 64'h0, 4'd6},
        '{1'b1, CR_EXCMSK,  64'hffff,              1'b0, 64'h0, 4'd6},
        '{1'b0, CR_EXCMSK,  64'h0,                 1'b0, 64'h0, 4'd6},
        '{1'b1, CR_INTID,   64'h55,                1'b1, 64'h0, 4'd7},   // R7
        '{1'b0, CR_INTID,   64'h0,                 1'b0, 64'h0, 4'd7},
        '{1'b1, CR_MMSTAT,  64'h1,                 1'b1, 64'h0, 4'd7},
        '{1'b1, CR_PTETMP,  64'h1,                 1'b1, 64'h0, 4'd7},
        '{1'b0, CR_PTETMP,  64'h0,                 1'b0, 64'h0, 4'd7},
        '{1'b1, CR_HWCLR,   64'h77,                1'b0, 64'h0, 4'd8},   // R8
        '{1'b0, CR_HWCLR,   64'h0,                 1'b1, 64'h0, 4'd8},
        '{1'b0, CR_INVALL,  64'h0,                 1'b1, 64'h0, 4'd8},
        '{1'b0, CR_INVPROC, 64'h0,                 1'b1, 64'h0, 4'd8},
        '{1'b0, CR_INVONE,  64'h0,                 1'b1, 64'h0, 4'd8},
        '{1'b1, 5'd25,      64'h3,                 1'b1, 64'h0, 4'd13},  // R13
        '{1'b0, 5'd31,      64'h0,                 1'b1, 64'h0, 4'd13},
        '{1'b0, CR_IPL,     64'h0,                 1'b0, 64'h1f, 4'd13},
        '{1'b1, CR_ASN,     64'h5,                 1'b0, 64'h0, 4'd12},  // R12
        '{1'b1, CR_PTE,     64'h8000_0123_0010_5a1b, 1'b0, 64'h0, 4'd12},
        '{1'b0, CR_PTE,     64'h0,                 1'b0, 64'h0a00_0123_0000_5a12, 4'd12},
        '{1'b0, CR_ASN,     64'h0,                 1'b0, 64'h5, 4'd12}
    };

    task automatic chk(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [4:0] idx, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] pulses();
        return {flush_all, flush_proc, flush_one, ins_pulse};
    endfunction

    initial begin
        logic [63:0] a, b;
        repeat (3) @(posedge clk);
        #1;
        // R14 reset state
        chk("R14", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        chk("R14", "pulses after reset", 64'(pulses()), 64'h0);
        rst_n = 1'b1;
        do_req(1'b0, CR_IPL, 64'h0);
        chk("R14", "ipl reset value", rsp_rdata, 64'h0);
        chk("R14", "response valid", 64'(rsp_valid), 64'h1);
        do_req(1'b0, CR_TAG, 64'h0);
        chk("R14", "tag reset value", rsp_rdata, 64'h0);
        idle_cycle();
        chk("R14", "no response when idle", 64'(rsp_valid), 64'h0);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].wr, VECS[i].idx, VECS[i].wd);
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("row %0d valid", i), 64'(rsp_valid), 64'h1);
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("row %0d fault", i), 64'(rsp_fault), 64'(VECS[i].flt));
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("row %0d data", i), rsp_rdata, VECS[i].exp);
        end

        // R9 cycle register
        do_req(1'b1, CR_CYCLE, 64'habcd_0000_1111_2222);
        do_req(1'b0, CR_CYCLE, 64'h0);
        a = rsp_rdata;
        do_req(1'b0, CR_CYCLE, 64'h0);
        b = rsp_rdata;
        chk("R9", "stored upper half", {32'h0, a[63:32]}, 64'habcd0000);
        chk("R9", "live lower half step", 64'(b[31:0] - a[31:0]), 64'h1);

        // R10 invalidate-all / by-process pulses
        do_req(1'b1, CR_INVALL, 64'hffff);
        chk("R10", "flush_all pulse", 64'(pulses()), 64'h8);
        idle_cycle();
        chk("R10", "flush_all dropped", 64'(pulses()), 64'h0);
        do_req(1'b1, CR_INVPROC, 64'h1);
        chk("R10", "flush_proc pulse", 64'(pulses()), 64'h4);
        idle_cycle();
        chk("R10", "flush_proc dropped", 64'(pulses()), 64'h0);

        // R11 single-address flush
        do_req(1'b1, CR_INVONE, 64'h4000);
        chk("R11", "flush_one pulse", 64'(pulses()), 64'h2);
        chk("R11", "flush address", flush_addr, 64'h4000);
        chk("R11", "flush asn", 64'(flush_asn), 64'h5);

        // R12 insert
        do_req(1'b1, CR_TAG, 64'h7000);
        chk("R12", "insert pulse", 64'(pulses()), 64'h1);
        chk("R12", "insert tag", ins_tag, 64'h7000);
        chk("R12", "insert entry", ins_entry, 64'h0a00_0123_0000_5a12);
        idle_cycle();
        chk("R12", "insert dropped", 64'(pulses()), 64'h0);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule